// File: doc/BRIEF.md
# Context-Adaptive Binary Arithmetic Bin Decoder

This core turns a compressed bitstream into bins, one bin for each request. A controller above it asks for a bin by giving a mode (context-coded, equiprobable or slice-terminating) and, for context-coded bins, a context index. The core keeps a 9-bit range and a 9-bit offset. Each context holds a 6-bit probability state and a most-probable-symbol bit. The contexts sit in a 399-entry store that has one read port and one write port.

Context-coded bins pass through two stages. In the first stage the core reads the context for the incoming request. In the second stage it splits the interval, returns the bin and writes the updated context back. It reads the context for the following request in that same cycle, so back-to-back requests yield one bin per cycle. A separate bit supplier sees the number of bits consumed in each decode cycle. In the same cycle it presents the next eight stream bits, MSB first, and the core takes the leading ones. The controller loads the context contents through a load port before a slice starts, and it loads the first nine offset bits with a slice-start strobe.

Top module: `cabac_bin_core`

## Requirements
- R1: While reset is held and in the first cycle after it, `bin_vld` is 0 and `shift_cnt` is 0.
- R2: A request taken at a clock edge gives `bin_vld`=1 with its bin during the following cycle. Requests on consecutive cycles give bins on consecutive cycles, one bin per cycle.
- R3: For a context-coded bin (mode 0), q = range[7:6] and the LPS width is ((288+64q)·(30000−440·state)) >> 16. If offset ≥ range−LPS width, the bin is the inverse of the MPS bit, the offset loses range−LPS width and the range becomes the LPS width. Otherwise the bin is the MPS bit and the range becomes range−LPS width.
- R4: After a context-coded bin, or after a terminating bin that decodes 0, the range is doubled until bit 8 is set. `shift_cnt` reports the number of doublings (0 to 8). The offset is shifted by the same amount, and its low bits are filled from the top `shift_cnt` bits of `refill_bits`.
- R5: A context word is {state[5:0], mps} with mps at bit 0. After an MPS the state goes up by one but stops at 62, and state 63 stays 63. After an LPS the state becomes s−1−(s>>2), or 0 when s is 0, and the MPS bit flips only when s is 0.
- R6: When a context-coded request uses the same index as the bin being decoded in that cycle, it sees that bin's updated context, not the stale stored value.
- R7: For a terminating bin (mode 2), the range first drops by 2. The bin is 1 when offset ≥ the reduced range. A 1 skips renormalization and gives `shift_cnt`=0.
- R8: For an equiprobable bin (mode 1), the offset takes one bit (`refill_bits[7]`). The bin is 1 when the doubled offset is ≥ range, and in that case the range is subtracted from it. The range stays the same, `shift_cnt` is 1, and the context store is not touched.
- R9: `slice_go` sets the range to 510 and the offset to `slice_bits`.
- R10: `ctx_ld` writes `ctx_ld_val` into entry `ctx_ld_idx`. Later bins that use that index decode with the loaded state and MPS bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| slice_go | input | 1 | Start slice: reset range, load offset |
| slice_bits | input | 9 | First nine offset bits |
| ctx_ld | input | 1 | Context load strobe |
| ctx_ld_idx | input | 9 | Context index to load |
| ctx_ld_val | input | 7 | Context word {state, mps} |
| req_vld | input | 1 | Bin request |
| req_mode | input | 2 | 0 context-coded, 1 equiprobable, 2 terminating |
| req_ctx | input | 9 | Context index of the request |
| bin_vld | output | 1 | Bin valid this cycle |
| bin_val | output | 1 | Decoded bin |
| shift_cnt | output | 4 | Stream bits consumed this cycle |
| refill_bits | input | 8 | Next stream bits, MSB first |

## Verification
Two things can happen in the same cycle. The second stage writes back a context while the first stage reads a context for the next request. When both use the same index, the read has to return the value being written. The bench provokes this with runs of back-to-back requests that repeat one index, and with alternating indices, inside a stream in which every cycle carries a request. It judges each bin against a sequential model kept in the bench, so a stale read shows up as a wrong bin or a wrong shift count one or more bins later. The bench also checks the MPS flip at state 0 and both outcomes of a terminating bin, starting each case from a crafted slice-start offset.

// File: rtl/cabac_bin_core.sv
module cabac_bin_core #(
  parameter int NCTX = 399,
  parameter int IDXW = $clog2(NCTX),
  parameter int STW  = 6,
  parameter int CW   = STW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            slice_go,
  input  logic [8:0]      slice_bits,
  input  logic            ctx_ld,
  input  logic [IDXW-1:0] ctx_ld_idx,
  input  logic [CW-1:0]   ctx_ld_val,
  input  logic            req_vld,
  input  logic [1:0]      req_mode,
  input  logic [IDXW-1:0] req_ctx,
  output logic            bin_vld,
  output logic            bin_val,
  output logic [3:0]      shift_cnt,
  input  logic [7:0]      refill_bits
);
  localparam logic [1:0] M_CTX = 2'd0, M_BYP = 2'd1, M_TRM = 2'd2;
  localparam logic [8:0] RNG_INIT = 9'd510;
  localparam logic [STW-1:0] ST_TOP = STW'(62);

  logic [CW-1:0]   mem [NCTX];
  logic [8:0]      rng, off;
  logic            s2_v;
  logic [1:0]      s2_mode;
  logic [IDXW-1:0] s2_idx;
  logic [CW-1:0]   s2_ctx;

  logic [STW-1:0]  st, st_nx;
  logic            mps, mps_nx;
  logic [23:0]     prod;
  logic [8:0]      lps_w, rmps, r_sub, o_sub, r_nx, o_nx;
  logic [9:0]      o_byp;
  logic            hit, skip, wr_en;
  logic [3:0]      sh;
  logic [16:0]     o_sh;
  logic [CW-1:0]   wb_val;

  assign st   = s2_ctx[CW-1:1];
  assign mps  = s2_ctx[0];
  assign prod = (24'(9'd288) + 24'({rng[7:6], 6'd0})) * 24'(15'd30000 - 15'(st * 9'd440));
  assign lps_w = prod[24-1:16] == 8'd0 ? 9'd1 : {1'b0, prod[23:16]};
  assign rmps  = rng - lps_w;
  assign o_byp = {off, refill_bits[7]};

  always_comb begin
    hit   = 1'b0;
    skip  = 1'b0;
    r_sub = rng;
    o_sub = off;
    unique case (s2_mode)
      M_BYP: begin
        hit  = o_byp >= {1'b0, rng};
        skip = 1'b1;
      end
      M_TRM: begin
        r_sub = rng - 9'd2;
        hit   = off >= r_sub;
        skip  = hit;
      end
      default: begin
        hit   = off >= rmps;
        r_sub = hit ? lps_w : rmps;
        o_sub = hit ? off - rmps : off;
      end
    endcase
  end

  always_comb begin
    sh = 4'd0;
    for (int i = 0; i < 9; i++)
      if (r_sub[i]) sh = 4'(8 - i);
  end

  assign o_sh = ({8'd0, o_sub} << sh) | 17'(refill_bits >> (4'd8 - sh));

  always_comb begin
    r_nx = r_sub;
    o_nx = o_sub;
    if (s2_mode == M_BYP) begin
      o_nx = hit ? 9'(o_byp - {1'b0, rng}) : o_byp[8:0];
    end else if (!skip) begin
      r_nx = r_sub << sh;
      o_nx = o_sh[8:0];
    end
  end

  always_comb begin
    if (hit) begin
      st_nx  = (st == '0) ? '0 : st - STW'(1) - (st >> 2);
      mps_nx = (st == '0) ? ~mps : mps;
    end else begin
      st_nx  = (st < ST_TOP) ? st + STW'(1) : st;
      mps_nx = mps;
    end
  end

  assign wb_val    = {st_nx, mps_nx};
  assign wr_en     = s2_v && (s2_mode == M_CTX);
  assign bin_vld   = s2_v;
  assign bin_val   = s2_v && ((s2_mode == M_CTX) ? (hit ? ~mps : mps) : hit);
  assign shift_cnt = !s2_v ? 4'd0 : (s2_mode == M_BYP) ? 4'd1 : skip ? 4'd0 : sh;

  always_ff @(posedge clk) begin
    if (ctx_ld) mem[ctx_ld_idx] <= ctx_ld_val;
    else if (wr_en) mem[s2_idx] <= wb_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v    <= 1'b0;
      s2_mode <= M_CTX;
      s2_idx  <= '0;
      s2_ctx  <= '0;
    end else begin
      s2_v <= req_vld;
      if (req_vld) begin
        s2_mode <= req_mode;
        s2_idx  <= req_ctx;
        s2_ctx  <= (wr_en && s2_idx == req_ctx) ? wb_val : mem[req_ctx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rng <= RNG_INIT;
      off <= '0;
    end else if (slice_go) begin
      rng <= RNG_INIT;
      off <= slice_bits;
    end else if (s2_v) begin
      rng <= r_nx;
      off <= o_nx;
    end
  end

  p_range_norm_r4: assert property (@(posedge clk) disable iff (!rst_n) rng[8]);
  p_shift_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_cnt <= 4'd8);
  p_one_per_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> bin_vld);
  p_bypass_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_v && s2_mode == M_BYP && !slice_go) |=> $stable(rng));
  p_term_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bin_vld && s2_mode == M_TRM && bin_val) |-> shift_cnt == 4'd0);
  p_slice_init_r9: assert property (@(posedge clk) disable iff (!rst_n)
    slice_go |=> rng == RNG_INIT);
endmodule

// File: tb/tb_cabac_bin_core.sv
module tb_cabac_bin_core;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slice_go = 0; logic [8:0] slice_bits = 0;
  logic ctx_ld = 0; logic [8:0] ctx_ld_idx = 0; logic [6:0] ctx_ld_val = 0;
  logic req_vld = 0; logic [1:0] req_mode = 0; logic [8:0] req_ctx = 0;
  logic bin_vld, bin_val; logic [3:0] shift_cnt; logic [7:0] refill_bits;

  always #2.5 clk = ~clk;

  cabac_bin_core dut (.clk, .rst_n, .slice_go, .slice_bits, .ctx_ld, .ctx_ld_idx,
    .ctx_ld_val, .req_vld, .req_mode, .req_ctx, .bin_vld, .bin_val, .shift_cnt,
    .refill_bits);

  bit stream [8192];
  int ptr = 0;
  always_comb for (int k = 0; k < 8; k++) refill_bits[7-k] = stream[ptr+k];
  always @(posedge clk) if (bin_vld) ptr <= ptr + int'(shift_cnt);

  int errors = 0, checks = 0, cyc = 0;
  bit finished = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // reference model
  int mrng, moff, mptr;
  logic [6:0] mctx [399];

  function automatic int lpsw(int s, int r);
    int v = ((288 + 64 * ((r >> 6) & 3)) * (30000 - 440 * s)) >> 16;
    return v == 0 ? 1 : v;
  endfunction

  task automatic model(input int mode, input int idx, output bit eb, output int esh);
    int s, m, lw, rm, r, o;
    bit lps;
    esh = 0;
    if (mode == 1) begin
      o = moff * 2 + int'(stream[mptr]); mptr++;
      eb = o >= mrng; if (eb) o -= mrng;
      moff = o; esh = 1; return;
    end
    if (mode == 2) begin
      r = mrng - 2; eb = moff >= r; mrng = r;
      if (eb) return;
    end else begin
      s = int'(mctx[idx][6:1]); m = int'(mctx[idx][0]);
      lw = lpsw(s, mrng); rm = mrng - lw;
      lps = moff >= rm;
      if (lps) begin
        eb = !m; moff -= rm; mrng = lw;
        if (s == 0) m = 1 - m;
        s = (s == 0) ? 0 : s - 1 - (s >> 2);
      end else begin
        eb = m; mrng = rm;
        if (s < 62) s++;
      end
      mctx[idx] = {6'(s), 1'(m)};
    end
    while (mrng < 256) begin
      mrng *= 2; moff = (moff * 2 + int'(stream[mptr])) & 511; mptr++; esh++;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  bit pend = 0; bit pb; int psh; string ptag;

  task automatic check_pend();
    if (pend) begin
      chk({ptag, " valid"}, int'(bin_vld), 1);
      chk({ptag, " bin"}, int'(bin_val), int'(pb));
      chk({ptag, " shift"}, int'(shift_cnt), psh);
    end
    pend = 0;
  endtask

  // drive at negedge; result of previous request is checked first
  task automatic issue(input int mode, input int idx, input string tag);
    @(negedge clk);
    check_pend();
    model(mode, idx, pb, psh);
    ptag = tag; pend = 1;
    req_vld = 1; req_mode = 2'(mode); req_ctx = 9'(idx);
  endtask

  task automatic drain();
    @(negedge clk);
    check_pend();
    req_vld = 0;
    @(negedge clk);
  endtask

  task automatic slice(input int bits);
    @(negedge clk);
    slice_go = 1; slice_bits = 9'(bits);
    mrng = 510; moff = bits; mptr = ptr;
    @(negedge clk);
    slice_go = 0;
  endtask

  task automatic load(input int idx, input logic [6:0] v);
    @(negedge clk);
    ctx_ld = 1; ctx_ld_idx = 9'(idx); ctx_ld_val = v; mctx[idx] = v;
    @(negedge clk);
    ctx_ld = 0;
  endtask

  // {mode, ctx}: runs of a repeated index exercise write-back forwarding (R6)
  localparam logic [10:0] VEC [28] = '{
    {2'd0, 9'd5}, {2'd0, 9'd5}, {2'd0, 9'd5}, {2'd0, 9'd6}, {2'd0, 9'd5},
    {2'd0, 9'd6}, {2'd1, 9'd0}, {2'd1, 9'd0}, {2'd1, 9'd0}, {2'd0, 9'd398},
    {2'd0, 9'd398}, {2'd0, 9'd0}, {2'd0, 9'd0}, {2'd0, 9'd0}, {2'd0, 9'd0},
    {2'd2, 9'd0}, {2'd0, 9'd77}, {2'd1, 9'd0}, {2'd0, 9'd77}, {2'd0, 9'd200},
    {2'd0, 9'd201}, {2'd0, 9'd200}, {2'd0, 9'd201}, {2'd1, 9'd0}, {2'd0, 9'd5},
    {2'd0, 9'd5}, {2'd0, 9'd63}, {2'd0, 9'd63}};

  initial begin
    logic [15:0] lf = 16'hACE1;
    for (int i = 0; i < 8192; i++) begin
      stream[i] = lf[0];
      lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    end
    repeat (3) @(negedge clk);
    chk("R1 reset valid", int'(bin_vld), 0);
    chk("R1 reset shift", int'(shift_cnt), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset valid", int'(bin_vld), 0);
    chk("R1 after reset shift", int'(shift_cnt), 0);

    // R10: fill every context through the load port
    for (int i = 0; i < 399; i++) load(i, {6'((i * 7) % 64), 1'(i % 2)});

    // R2 R3 R4 R5 R6 R8: back-to-back table walk, three slices
    for (int pass = 0; pass < 3; pass++) begin
      slice(37 + pass * 150);
      for (int v = 0; v < 28; v++)
        issue(int'(VEC[v][10:9]), int'(VEC[v][8:0]), $sformatf("R3 vec%0d", v));
      drain();
    end

    // R5: LPS at state 0 flips MPS; 510 -> lps 219, rmps 291, offset 300 is LPS
    load(10, 7'b0000000);
    slice(300);
    issue(0, 10, "R5 lps at state0");
    @(negedge clk);
    chk("R5 lps bin", int'(bin_val), 1);
    chk("R4 lps shift", int'(shift_cnt), 1);
    check_pend();
    model(0, 10, pb, psh); pend = 1; ptag = "R5 flipped mps";
    req_mode = 2'd0; req_ctx = 9'd10;
    drain();
    chk("R5 model mps flipped", int'(mctx[10][0]), 1);

    // R7: terminating hit, offset 509 >= 508
    slice(509);
    issue(2, 0, "R7 term hit");
    @(negedge clk);
    chk("R7 term hit bin", int'(bin_val), 1);
    chk("R7 term hit shift", int'(shift_cnt), 0);
    check_pend();
    req_vld = 0;
    // R7: terminating miss, range 508 keeps bit 8, no shift
    slice(100);
    issue(2, 0, "R7 term miss");
    @(negedge clk);
    chk("R7 term miss bin", int'(bin_val), 0);
    chk("R7 term miss shift", int'(shift_cnt), 0);
    check_pend();
    req_vld = 0;

    // R8: bypass, offset 300 with range 510: doubled ~600 >= 510 gives 1
    slice(300);
    issue(1, 0, "R8 bypass");
    @(negedge clk);
    chk("R8 bypass bin", int'(bin_val), 1);
    chk("R8 bypass shift", int'(shift_cnt), 1);
    check_pend();
    req_vld = 0;
    // R8/R9: range unchanged after bypass, so second bypass model matches
    issue(1, 0, "R8 bypass again");
    drain();

    // R10: high state loaded, MPS path 63 stays 63
    load(300, {6'd63, 1'b1});
    slice(20);
    issue(0, 300, "R10 loaded state63");
    issue(0, 300, "R5 state63 hold");
    drain();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule